// File: doc/BRIEF.md
# Bridge Read Prefetch Policy Controller

This block sits on the downstream read path of a PCI-to-PCI bridge. For every inbound memory read it picks how many dwords the bridge should fetch from the upstream side. The choice depends on the read command type, a disable bit for each command and a global single-dword override. Every fetch is clipped so that it stays inside the aligned region that matches its length. The block applies the same clipping to the start address when it computes the length.

The same block decides whether a new delayed read may enter the bridge. It counts the reads that are active and the reads that are pending, and compares that count against one of several programmable limits. Reads that do not fit are answered with retry. When a completion is consumed, its active slot is freed, and the oldest pending read is promoted into that slot in the same cycle. A one-cycle strobe reports each read that starts an upstream fetch.

If auto-flush is enabled, a disconnect event (the master ending the transfer, or the bridge stopping it) produces a registered one-cycle flush strobe that discards all buffered prefetch data. If auto-flush is disabled, the block never flushes, and discard is left to the normal buffer rules elsewhere.

Top module: `rd_prefetch_ctrl`

## Requirements
- R1: After reset, and for as long as no request or event is applied, accept_o, retry_o, start_o and flush_o are all low.
- R2: With configuration bit 3 (single-dword override) set, every request reports a fetch length of 1, whatever its command.
- R3: A plain read (command code 00) with configuration bit 0 clear fetches up to the end of its 64-byte line, which is 16 minus address bits [5:2]. With bit 0 set it fetches 1 dword.
- R4: A line read (command code 01) with configuration bit 1 clear fetches up to the end of its 256-byte aligned four-line window, which is 64 minus address bits [7:2]. With bit 1 set it fetches up to the end of its 64-byte line.
- R5: A multiple read (command code 10) follows the R4 rule, using configuration bit 2 as its disable bit. The bits of the other commands have no effect on it.
- R6: Command code 11 is handled exactly like a plain read.
- R7: Configuration bits [7:6] set the admission limit. Code 00 allows 2 active and 5 pending (7 in total). Code 01 allows 2 active and none pending. Code 10 allows 1 active and none pending. Code 11 acts as 00. While req_valid_i is high, exactly one of accept_o and retry_o is high, in the same cycle. A request is retried when the occupancy held at the start of that cycle has reached the limit. A completion in that same cycle is not counted.
- R8: A done_i pulse frees one active slot and is ignored when no read is active. In the same cycle the oldest pending read is promoted to active. start_o is high in the cycle after a read becomes active, whether it was accepted straight into a free active slot or promoted.
- R9: With configuration bit 4 set, a rising edge on disconnect_i makes flush_o high for exactly one cycle, in the cycle after the edge. If disconnect_i is held high, it still gives only one pulse.
- R10: With configuration bit 4 clear, disconnect_i never causes flush_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 8 | Policy byte: [0] plain-read disable, [1] line-read disable, [2] multiple-read disable, [3] single-dword override, [4] auto-flush, [5] unused, [7:6] admission limit |
| req_valid_i | input | 1 | A read request is presented this cycle |
| req_cmd_i | input | 2 | Read command: 00 plain, 01 line, 10 multiple, 11 as plain |
| req_addr_i | input | AW | Byte start address of the read |
| done_i | input | 1 | A completion has been consumed; frees one active slot |
| disconnect_i | input | 1 | The transfer was disconnected by the master or by the bridge |
| fetch_dw_o | output | 7 | Fetch length in dwords for the presented request |
| accept_o | output | 1 | Request admitted (combinational) |
| retry_o | output | 1 | Request refused; the master must retry (combinational) |
| start_o | output | 1 | A read became active in the previous cycle |
| flush_o | output | 1 | Registered one-cycle strobe that discards buffered prefetch data |

## Verification
The assertions assume that req_cmd_i, req_addr_i and cfg_i are stable and valid whenever req_valid_i is high. They also assume that done_i is asserted only as a single-cycle pulse for each consumed completion. The bench drives every input one time unit after the rising edge and holds it for the whole cycle, so the combinational length and admission outputs settle before they are checked. Registered outputs are checked one time unit after the following edge. done_i and disconnect_i are driven as pulses of one clock cycle, except in the deliberate held-disconnect case. The configuration byte is changed only between requests.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

  typedef enum logic [1:0] {
    CMD_MR  = 2'b00,
    CMD_MRL = 2'b01,
    CMD_MRM = 2'b10,
    CMD_RSV = 2'b11
  } rd_cmd_e;

  typedef struct packed {
    logic [1:0] dt_lim;
    logic       spare;
    logic       auto_flush;
    logic       one_dw;
    logic       mrm_dis;
    logic       mrl_dis;
    logic       mr_dis;
  } pf_cfg_t;

  localparam int unsigned ACT_MAX  = 2;
  localparam int unsigned PEND_MAX = 5;
  localparam int unsigned CNT_W    = $clog2(ACT_MAX + PEND_MAX + 1);

endpackage

// File: rtl/rpf_len_calc.sv
module rpf_len_calc
  import rpf_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned LINE_DW  = 16,
  parameter int unsigned PF_LINES = 4,
  parameter int unsigned LEN_W    = 7
) (
  input  pf_cfg_t          cfg_i,
  input  rd_cmd_e          cmd_i,
  input  logic [AW-1:0]    addr_i,
  output logic [LEN_W-1:0] len_o
);

  localparam int unsigned PF_DW   = LINE_DW * PF_LINES;
  localparam int unsigned LINE_SH = $clog2(LINE_DW);
  localparam int unsigned PF_SH   = $clog2(PF_DW);

  logic [LEN_W-1:0] to_line, to_pf;
  logic             multi, line;

  assign to_line = LEN_W'(LINE_DW) - LEN_W'(addr_i[LINE_SH+1:2]);

  generate
    if (PF_LINES > 1) begin : g_multi
      assign to_pf = LEN_W'(PF_DW) - LEN_W'(addr_i[PF_SH+1:2]);
    end else begin : g_single
      assign to_pf = to_line;
    end
  endgenerate

  always_comb begin
    multi = 1'b0;
    line  = 1'b0;
    case (cmd_i)
      CMD_MRL: begin
        multi = !cfg_i.mrl_dis;
        line  = cfg_i.mrl_dis;
      end
      CMD_MRM: begin
        multi = !cfg_i.mrm_dis;
        line  = cfg_i.mrm_dis;
      end
      default: line = !cfg_i.mr_dis;  // plain read and code 11
    endcase
  end

  always_comb begin
    if (cfg_i.one_dw)  len_o = LEN_W'(1);
    else if (multi)    len_o = to_pf;
    else if (line)     len_o = to_line;
    else               len_o = LEN_W'(1);
  end

  logic unused_bits;
  assign unused_bits = ^{addr_i[AW-1:PF_SH+2], addr_i[1:0], cfg_i.dt_lim,
                         cfg_i.spare, cfg_i.auto_flush};

endmodule

// File: rtl/rpf_dt_admit.sv
module rpf_dt_admit
  import rpf_pkg::*;
#(
  parameter int unsigned A_MAX = ACT_MAX,
  parameter int unsigned P_MAX = PEND_MAX,
  parameter int unsigned CW    = CNT_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] lim_i,
  input  logic       req_valid_i,
  input  logic       done_i,
  output logic       accept_o,
  output logic       retry_o,
  output logic       start_o
);

  logic [CW-1:0] act_q, pend_q, act_d, pend_d;
  logic [CW-1:0] act_lim, pend_lim;
  logic [CW:0]   occ, tot_lim;
  logic          start_d, promote, to_act;

  always_comb begin
    case (lim_i)
      2'b01:   begin act_lim = CW'(A_MAX); pend_lim = '0; end
      2'b10:   begin act_lim = CW'(1);     pend_lim = '0; end
      default: begin act_lim = CW'(A_MAX); pend_lim = CW'(P_MAX); end
    endcase
  end

  assign occ      = {1'b0, act_q} + {1'b0, pend_q};
  assign tot_lim  = {1'b0, act_lim} + {1'b0, pend_lim};
  assign accept_o = req_valid_i && (occ < tot_lim);
  assign retry_o  = req_valid_i && !accept_o;

  always_comb begin
    act_d   = act_q;
    pend_d  = pend_q;
    promote = 1'b0;
    to_act  = 1'b0;
    if (done_i && act_q != '0) act_d = act_d - CW'(1);
    if (pend_d != '0 && act_d < act_lim) begin
      promote = 1'b1;
      act_d   = act_d + CW'(1);
      pend_d  = pend_d - CW'(1);
    end
    if (accept_o) begin
      if (pend_d == '0 && act_d < act_lim) begin
        to_act = 1'b1;
        act_d  = act_d + CW'(1);
      end else begin
        pend_d = pend_d + CW'(1);
      end
    end
    start_d = promote || to_act;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= '0;
      pend_q  <= '0;
      start_o <= 1'b0;
    end else begin
      act_q   <= act_d;
      pend_q  <= pend_d;
      start_o <= start_d;
    end
  end

endmodule

// File: rtl/rpf_flush_gen.sv
module rpf_flush_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_flush_i,
  input  logic disconnect_i,
  output logic flush_o
);

  logic disc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disc_q  <= 1'b0;
      flush_o <= 1'b0;
    end else begin
      disc_q  <= disconnect_i;
      flush_o <= auto_flush_i && disconnect_i && !disc_q;
    end
  end

endmodule

// File: rtl/rd_prefetch_ctrl.sv
module rd_prefetch_ctrl
  import rpf_pkg::*;
#(
  parameter  int unsigned AW       = 32,
  parameter  int unsigned LINE_DW  = 16,
  parameter  int unsigned PF_LINES = 4,
  localparam int unsigned LEN_W    = $clog2(LINE_DW * PF_LINES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       cfg_i,
  input  logic             req_valid_i,
  input  logic [1:0]       req_cmd_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic             done_i,
  input  logic             disconnect_i,
  output logic [LEN_W-1:0] fetch_dw_o,
  output logic             accept_o,
  output logic             retry_o,
  output logic             start_o,
  output logic             flush_o
);

  pf_cfg_t cfg;
  rd_cmd_e cmd;

  assign cfg = pf_cfg_t'(cfg_i);
  assign cmd = rd_cmd_e'(req_cmd_i);

  rpf_len_calc #(
    .AW(AW), .LINE_DW(LINE_DW), .PF_LINES(PF_LINES), .LEN_W(LEN_W)
  ) u_len (
    .cfg_i (cfg),
    .cmd_i (cmd),
    .addr_i(req_addr_i),
    .len_o (fetch_dw_o)
  );

  rpf_dt_admit u_admit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lim_i      (cfg.dt_lim),
    .req_valid_i(req_valid_i),
    .done_i     (done_i),
    .accept_o   (accept_o),
    .retry_o    (retry_o),
    .start_o    (start_o)
  );

  rpf_flush_gen u_flush (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .auto_flush_i(cfg.auto_flush),
    .disconnect_i(disconnect_i),
    .flush_o     (flush_o)
  );

endmodule

// File: rtl/rpf_checker.sv
module rpf_checker #(
  parameter int unsigned AW       = 32,
  parameter int unsigned LINE_DW  = 16,
  parameter int unsigned PF_LINES = 4,
  parameter int unsigned LEN_W    = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       cfg_i,
  input logic             req_valid_i,
  input logic [1:0]       req_cmd_i,
  input logic [AW-1:0]    req_addr_i,
  input logic             done_i,
  input logic [LEN_W-1:0] fetch_dw_o,
  input logic             accept_o,
  input logic             retry_o,
  input logic             start_o,
  input logic             flush_o
);

  localparam int unsigned PF_DW   = LINE_DW * PF_LINES;
  localparam int unsigned LINE_SH = $clog2(LINE_DW);
  localparam int unsigned PF_SH   = $clog2(PF_DW);

  int unsigned pf_idx, line_idx;
  logic        plain;
  assign pf_idx   = int'(req_addr_i[PF_SH+1:2]);
  assign line_idx = int'(req_addr_i[LINE_SH+1:2]);
  assign plain    = (req_cmd_i == 2'b00) || (req_cmd_i == 2'b11);

  AST_RESP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (accept_o ^ retry_o)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!accept_o && !retry_o)); // R1
  AST_ONE_DW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cfg_i[3]) |-> (fetch_dw_o == LEN_W'(1))); // R2
  AST_NO_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (fetch_dw_o != '0 && pf_idx + int'(fetch_dw_o) <= PF_DW)); // R4
  AST_MR_IN_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && plain) |-> (line_idx + int'(fetch_dw_o) <= LINE_DW)); // R3
  AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_valid_i && accept_o) && !done_i) |=> !start_o); // R8
  AST_FLUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o); // R9
  AST_NO_FLUSH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i[4] |=> !flush_o); // R10

  logic unused_chk;
  assign unused_chk = ^{req_addr_i[AW-1:PF_SH+2], req_addr_i[1:0]};

endmodule

bind rd_prefetch_ctrl rpf_checker #(
  .AW(AW), .LINE_DW(LINE_DW), .PF_LINES(PF_LINES), .LEN_W(LEN_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_i      (cfg_i),
  .req_valid_i(req_valid_i),
  .req_cmd_i  (req_cmd_i),
  .req_addr_i (req_addr_i),
  .done_i     (done_i),
  .fetch_dw_o (fetch_dw_o),
  .accept_o   (accept_o),
  .retry_o    (retry_o),
  .start_o    (start_o),
  .flush_o    (flush_o)
);

// File: tb/sim_rd_prefetch_ctrl.sv
module sim_rd_prefetch_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  // {cfg[4:0], cmd, addr[7:0], expected length}
  localparam logic [21:0] VEC [NVEC] = '{
    {5'h00, 2'd0, 8'h00, 7'd16},  // R3
    {5'h00, 2'd0, 8'h3C, 7'd1},   // R3
    {5'h00, 2'd0, 8'h14, 7'd11},  // R3
    {5'h01, 2'd0, 8'h00, 7'd1},   // R3
    {5'h00, 2'd1, 8'h00, 7'd64},  // R4
    {5'h00, 2'd1, 8'h44, 7'd47},  // R4
    {5'h02, 2'd1, 8'h44, 7'd15},  // R4
    {5'h04, 2'd1, 8'h00, 7'd64},  // R4
    {5'h00, 2'd2, 8'hFC, 7'd1},   // R5
    {5'h04, 2'd2, 8'h80, 7'd16},  // R5
    {5'h02, 2'd2, 8'h80, 7'd32},  // R5
    {5'h08, 2'd2, 8'h00, 7'd1},   // R2
    {5'h08, 2'd1, 8'h10, 7'd1},   // R2
    {5'h00, 2'd3, 8'h08, 7'd14},  // R6
    {5'h01, 2'd3, 8'h08, 7'd1}    // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_cmd = '0;
  logic [31:0] req_addr = '0;
  logic        done = 1'b0;
  logic        disc = 1'b0;
  logic [6:0]  fetch_dw;
  logic        accept, retry, start, flush;

  int errs = 0;
  int checks = 0;

  rd_prefetch_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .req_valid_i(req_valid),
    .req_cmd_i(req_cmd), .req_addr_i(req_addr), .done_i(done),
    .disconnect_i(disc), .fetch_dw_o(fetch_dw), .accept_o(accept),
    .retry_o(retry), .start_o(start), .flush_o(flush)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [7:0] c);
    rst_n = 1'b0; cfg = c; req_valid = 0; done = 0; disc = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
  endtask

  task automatic send(input bit exp_acc, input string tag);
    req_valid = 1'b1;
    #1;
    chk({tag, " accept"}, int'(accept), int'(exp_acc));
    chk({tag, " retry"}, int'(retry), int'(!exp_acc));
    tick();
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    do_reset(8'h00);
    chk("R1 accept idle", int'(accept), 0);
    chk("R1 retry idle", int'(retry), 0);
    chk("R1 start idle", int'(start), 0);
    chk("R1 flush idle", int'(flush), 0);

    // length table
    for (int i = 0; i < NVEC; i++) begin
      cfg = {3'b000, VEC[i][21:17]};
      req_cmd = VEC[i][16:15];
      req_addr = {24'hA5C3E1, VEC[i][14:7]};
      req_valid = 1'b1;
      #1;
      chk($sformatf("R2-6 len vec%0d", i), int'(fetch_dw), int'(VEC[i][6:0]));
      tick();
      req_valid = 1'b0;
    end

    // R7/R8 limit code 00
    do_reset(8'h00);
    send(1, "R7 m00 r1"); chk("R8 start direct", int'(start), 1);
    send(1, "R7 m00 r2"); chk("R8 start direct2", int'(start), 1);
    send(1, "R7 m00 r3"); chk("R8 pending no start", int'(start), 0);
    for (int i = 4; i <= 7; i++) send(1, "R7 m00 fill");
    send(0, "R7 m00 full");
    done = 1'b1; tick(); done = 1'b0;
    chk("R8 promote start", int'(start), 1);
    send(1, "R7 m00 after free");
    send(0, "R7 m00 full again");

    // limit code 10, ignored done, same-cycle completion
    do_reset(8'h80);
    done = 1'b1; tick(); done = 1'b0;
    chk("R8 done idle no start", int'(start), 0);
    send(1, "R8 done idle ignored");
    chk("R8 start m10", int'(start), 1);
    done = 1'b1;
    send(0, "R7 same-cycle done not counted");
    done = 1'b0;
    send(1, "R7 m10 after free");

    // limit code 01
    do_reset(8'h40);
    send(1, "R7 m01 r1");
    send(1, "R7 m01 r2"); chk("R8 start m01", int'(start), 1);
    send(0, "R7 m01 full");

    // limit code 11 acts as 00
    do_reset(8'hC0);
    for (int i = 0; i < 7; i++) send(1, "R7 m11 fill");
    send(0, "R7 m11 full");

    // flush
    do_reset(8'h10);
    disc = 1'b1; tick();
    chk("R9 flush pulse", int'(flush), 1);
    tick();
    chk("R9 held no repeat", int'(flush), 0);
    tick();
    chk("R9 held no repeat2", int'(flush), 0);
    disc = 1'b0; tick();
    disc = 1'b1; tick(); disc = 1'b0;
    chk("R9 second edge", int'(flush), 1);
    tick();
    chk("R9 one cycle", int'(flush), 0);
    cfg = 8'h00;
    disc = 1'b1; tick(); disc = 1'b0;
    chk("R10 no flush", int'(flush), 0);
    tick();
    chk("R10 no flush later", int'(flush), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule